// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one programmable timer channel. A down counter steps once per prescaler pulse and divides the timer clock by 1, 16 or 256. It runs free, runs periodically from a reload value, or fires once and stops. Software picks a 16-bit or 32-bit count width at run time. The 32-bit count register always keeps its upper half, so switching to the narrow width and back loses nothing. When the count steps from 1 to 0, a sticky raw interrupt flag is set. The interrupt output is that flag gated by an enable bit.

Access goes through a single-cycle register port. A write takes a strobe, an offset and data. Reads are combinational from the offset. A write lands on the clock edge at which the strobe is sampled. Any counting step at that same edge is computed first, and the write then overrides the fields it touches.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset the control register reads 0x20, the reload value reads 0, the count reads 0xFFFFFFFF, the raw and masked status read 0, `irq` is low, and the count does not change.
- R2: The `reg_offs` map is: 0 control, 1 load, 2 background load, 3 count, 4 raw status (bit 0), 5 masked status (bit 0), 6 interrupt clear (write only). Control bits are: bit 7 enable, bit 6 periodic (0 means free-running), bit 5 interrupt enable, bits 3:2 prescale, bit 1 wide (1 means 32-bit), bit 0 one-shot. Control bit 4 and bits above 7 read 0. Offsets 1 and 2 both read the stored reload value. Offsets 6 and 7 read 0.
- R3: While enabled, the count steps once every 1, 16 or 256 clock cycles for prescale codes 00, 01 and 10. Code 11 acts like 10. A control write that changes the prescale code restarts the divide phase.
- R4: A load write sets both the reload value and the full 32-bit count to the written data. In periodic mode, a load whose active-width part is zero stops counting.
- R5: A background-load write changes only the reload value. The count is left untouched.
- R6: In periodic mode, a step taken from count 0 reloads the active-width part from the reload value.
- R7: In free-running mode, a step taken from count 0 sets the active-width part to all ones (0xFFFF or 0xFFFFFFFF).
- R8: In 16-bit mode only bits 15:0 count, and bits 31:16 hold their value. A count read returns both halves joined. A size switch leaves the 32-bit count unchanged.
- R9: A step from 1 to 0 sets the raw flag. Any write to offset 6 clears it, unless a setting step lands on the same edge, in which case the set wins. Masked status and `irq` equal the raw flag AND interrupt enable.
- R10: In one-shot mode the counter halts after the 1-to-0 step. A control write with enable set resumes counting, even when enable was already set.
- R11: With enable clear, the count and the prescaler phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_offs | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_offs` |
| irq | output | 1 | Masked interrupt |

## Verification
Any slip in the count register shows on the count read in the same cycle. A wrong reload or wrap value appears one step after the counter passes zero. A prescaler phase error shifts every later step, so it is visible within one divide period. A halt or run flag stuck at the wrong value shows as a count that keeps moving, or that freezes, on the next pulse. For this reason the bench compares `reg_rdata` and `irq` with a behavioural model on every clock. It also makes directed checks at the exact edges where reload, wrap, halt and clear-versus-set collisions occur.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       inten;
        logic       spare;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } tmr_ctrl_t;

    localparam int OFFS_W = 3;

    typedef enum logic [OFFS_W-1:0] {
        OFF_CTRL   = 3'd0,
        OFF_LOAD   = 3'd1,
        OFF_BGLOAD = 3'd2,
        OFF_VALUE  = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5,
        OFF_CLEAR  = 3'd6
    } tmr_offs_e;

    localparam logic [7:0] CTRL_WMASK = 8'hEF;
    localparam tmr_ctrl_t  CTRL_RESET = 8'h20;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int LOG_MID = 4,
    parameter int LOG_HI  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int CW = LOG_HI;
    localparam logic [CW-1:0] MID_LIMIT = CW'((1 << LOG_MID) - 1);
    localparam logic [CW-1:0] HI_LIMIT  = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        case (code)
            2'b00:   limit = '0;
            2'b01:   limit = MID_LIMIT;
            default: limit = HI_LIMIT;   // 10 and 11 share the slowest rate
        endcase
        tick = active && (st_q.cnt == limit);
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (active) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code != 2'b00 && !restart) |=> !tick);  // R3

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int TW = 32,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          periodic,
    input  logic          wide,
    input  logic          oneshot,
    input  logic          tick,
    input  logic          load_wr,
    input  logic          bg_wr,
    input  logic          ctrl_en_wr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] count,
    output logic [TW-1:0] reload,
    output logic          run,
    output logic          expire
);
    localparam logic [TW-1:0] NARROW_MASK = {{(TW-NW){1'b0}}, {NW{1'b1}}};
    localparam logic [TW-1:0] ONE         = {{(TW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TW-1:0] count;
        logic [TW-1:0] reload;
        logic          run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [TW-1:0] wmask, live, next_live;

    always_comb begin
        wmask     = wide ? {TW{1'b1}} : NARROW_MASK;
        live      = st_q.count & wmask;
        expire    = tick && (live == ONE);
        if (live == '0) next_live = periodic ? (st_q.reload & wmask) : wmask;
        else            next_live = live - ONE;

        st_d = st_q;
        if (tick) begin
            st_d.count = (st_q.count & ~wmask) | (next_live & wmask);
            if (expire && oneshot) st_d.run = 1'b0;
        end
        if (load_wr) begin
            st_d.reload = wdata;
            st_d.count  = wdata;
            if (periodic) st_d.run = ((wdata & wmask) != '0);
        end
        if (bg_wr)      st_d.reload = wdata;
        if (ctrl_en_wr) st_d.run    = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count  <= {TW{1'b1}};
            st_q.reload <= '0;
            st_q.run    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.count;
    assign reload = st_q.reload;
    assign run    = st_q.run;

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot && !load_wr && !ctrl_en_wr) |=> !run);  // R10

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && live == '0 && !periodic && !load_wr && !ctrl_en_wr)
        |=> ((count & wmask) == wmask));  // R7

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_wr) |=> $stable(count));  // R11

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !load_wr) |=> (count[TW-1:NW] == $past(count[TW-1:NW])));  // R8

endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
    parameter int TW          = 32,
    parameter int NW          = 16,
    parameter int PRE_LOG_MID = 4,
    parameter int PRE_LOG_HI  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [tmr_pkg::OFFS_W-1:0] reg_offs,
    input  logic [TW-1:0]              reg_wdata,
    output logic [TW-1:0]              reg_rdata,
    output logic                       irq
);
    import tmr_pkg::*;

    typedef struct packed {
        tmr_ctrl_t ctrl;
        logic      raw;
    } top_state_t;

    top_state_t st_d, st_q;

    logic          ctrl_wr, load_wr, bg_wr, clr_wr;
    tmr_ctrl_t     new_ctrl;
    logic          restart, active, tick, run, expire;
    logic [TW-1:0] count, reload;

    always_comb begin
        ctrl_wr  = reg_wr && (reg_offs == OFF_CTRL);
        load_wr  = reg_wr && (reg_offs == OFF_LOAD);
        bg_wr    = reg_wr && (reg_offs == OFF_BGLOAD);
        clr_wr   = reg_wr && (reg_offs == OFF_CLEAR);
        new_ctrl = tmr_ctrl_t'(reg_wdata[7:0] & CTRL_WMASK);
        restart  = ctrl_wr && (new_ctrl.presc != st_q.ctrl.presc);
        active   = st_q.ctrl.en && run;

        st_d = st_q;
        if (ctrl_wr) st_d.ctrl = new_ctrl;
        if (expire)      st_d.raw = 1'b1;
        else if (clr_wr) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RESET;
            st_q.raw  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_prescaler #(
        .LOG_MID (PRE_LOG_MID),
        .LOG_HI  (PRE_LOG_HI)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .restart (restart),
        .code    (st_q.ctrl.presc),
        .tick    (tick)
    );

    tmr_counter #(
        .TW (TW),
        .NW (NW)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (st_q.ctrl.en),
        .periodic   (st_q.ctrl.periodic),
        .wide       (st_q.ctrl.wide),
        .oneshot    (st_q.ctrl.oneshot),
        .tick       (tick),
        .load_wr    (load_wr),
        .bg_wr      (bg_wr),
        .ctrl_en_wr (ctrl_wr && new_ctrl.en),
        .wdata      (reg_wdata),
        .count      (count),
        .reload     (reload),
        .run        (run),
        .expire     (expire)
    );

    always_comb begin
        case (reg_offs)
            OFF_CTRL:   reg_rdata = {{(TW-8){1'b0}}, st_q.ctrl};
            OFF_LOAD,
            OFF_BGLOAD: reg_rdata = reload;
            OFF_VALUE:  reg_rdata = count;
            OFF_RAW:    reg_rdata = {{(TW-1){1'b0}}, st_q.raw};
            OFF_MASKED: reg_rdata = {{(TW-1){1'b0}}, st_q.raw & st_q.ctrl.inten};
            default:    reg_rdata = '0;
        endcase
        irq = st_q.raw && st_q.ctrl.inten;
    end

    AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.raw);  // R9

    AST_RAW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !st_q.raw);  // R9

endmodule

// File: tb/prescaled_down_timer_tb.sv
module prescaled_down_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_offs = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    logic [7:0]  m_ctrl;
    logic [31:0] m_load, m_cnt;
    logic        m_run, m_raw;
    int          m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaled_down_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_offs  (reg_offs),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] model_read(input logic [2:0] o);
        case (o)
            3'd0:      return {24'd0, m_ctrl};
            3'd1, 3'd2: return m_load;
            3'd3:      return m_cnt;
            3'd4:      return {31'd0, m_raw};
            3'd5:      return {31'd0, m_raw & m_ctrl[5]};
            default:   return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 8'h20; m_load = 0; m_cnt = 32'hFFFF_FFFF;
            m_run = 1; m_raw = 0; m_pc = 0;
        end else begin
            int div;
            logic [31:0] mask, live, nl, n_cnt, n_load;
            logic [7:0] n_ctrl, nc;
            logic n_run, n_raw, act, stepped, exp;
            int n_pc;
            div  = (m_ctrl[3:2] == 2'b00) ? 1 : (m_ctrl[3:2] == 2'b01) ? 16 : 256;
            mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            act  = m_ctrl[7] && m_run;
            stepped = act && (m_pc == div - 1);
            n_cnt = m_cnt; n_load = m_load; n_ctrl = m_ctrl;
            n_run = m_run; n_raw = m_raw; n_pc = m_pc; exp = 0;
            if (act) n_pc = stepped ? 0 : m_pc + 1;
            if (stepped) begin
                live = m_cnt & mask;
                if (live == 1) begin
                    exp = 1; n_raw = 1;
                    if (m_ctrl[0]) n_run = 0;
                end
                nl = (live == 0) ? (m_ctrl[6] ? (m_load & mask) : mask) : live - 1;
                n_cnt = (m_cnt & ~mask) | (nl & mask);
            end
            if (reg_wr) begin
                case (reg_offs)
                    3'd0: begin
                        nc = reg_wdata[7:0] & 8'hEF;
                        if (nc[3:2] != m_ctrl[3:2]) n_pc = 0;
                        if (nc[7]) n_run = 1;
                        n_ctrl = nc;
                    end
                    3'd1: begin
                        n_load = reg_wdata; n_cnt = reg_wdata;
                        if (m_ctrl[6]) n_run = ((reg_wdata & mask) != 0);
                    end
                    3'd2: n_load = reg_wdata;
                    3'd6: if (!exp) n_raw = 0;
                    default: ;
                endcase
            end
            m_ctrl = n_ctrl; m_load = n_load; m_cnt = n_cnt;
            m_run = n_run; m_raw = n_raw; m_pc = n_pc;
        end
    end

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (reg_rdata !== model_read(reg_offs) || irq !== (m_raw & m_ctrl[5])) begin
                errors++;
                $display("FAIL %s model offs=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         cur_req, reg_offs, reg_rdata, irq, model_read(reg_offs), m_raw & m_ctrl[5]);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] o, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_offs = o; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_offs = 3'd3;
    endtask

    task automatic chk(input string tag, input logic [2:0] o, input logic [31:0] exp);
        reg_offs = o; #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s offs=%0d actual=%h expected=%h", tag, o, reg_rdata, exp);
        end
        reg_offs = 3'd3;
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", 3'd0, 32'h20);
        chk("R1", 3'd1, 32'h0);
        chk("R1", 3'd3, 32'hFFFF_FFFF);
        chk("R1", 3'd4, 32'h0);
        chk("R1", 3'd5, 32'h0);
        chk_irq("R1", 1'b0);
        wait_cyc(5);
        chk("R1", 3'd3, 32'hFFFF_FFFF);

        // R2 field masking and unused offsets
        cur_req = "R2";
        wr(3'd0, 32'hFFFF_FF1F);
        chk("R2", 3'd0, 32'h0F);
        chk("R2", 3'd7, 32'h0);
        chk("R2", 3'd6, 32'h0);
        wr(3'd0, 32'h20);

        // R4, R6, R9 periodic 16-bit, divide by 1
        cur_req = "R6";
        wr(3'd1, 32'd3);
        chk("R4", 3'd3, 32'd3);
        wr(3'd0, 32'hE0);
        wait_cyc(3);
        chk("R9", 3'd3, 32'd0);
        chk("R9", 3'd4, 32'd1);
        chk_irq("R9", 1'b1);
        wait_cyc(1);
        chk("R6", 3'd3, 32'd3);
        cur_req = "R9";
        wr(3'd6, 32'd0);
        chk("R9", 3'd4, 32'd0);
        wr(3'd0, 32'hC0);
        chk("R9", 3'd4, 32'd1);
        chk("R9", 3'd5, 32'd0);
        chk_irq("R9", 1'b0);

        // R11 freeze, R4 load, R5 background load
        cur_req = "R11";
        wr(3'd0, 32'h40);
        reg_offs = 3'd3; #1 v = reg_rdata;
        wait_cyc(4);
        chk("R11", 3'd3, v);
        cur_req = "R5";
        wr(3'd1, 32'h10);
        chk("R4", 3'd3, 32'h10);
        chk("R4", 3'd1, 32'h10);
        wr(3'd2, 32'h5);
        chk("R5", 3'd3, 32'h10);
        chk("R5", 3'd2, 32'h5);
        wr(3'd0, 32'hC0);
        wait_cyc(16);
        chk("R6", 3'd3, 32'h0);
        wait_cyc(1);
        chk("R5", 3'd3, 32'h5);

        // R4 zero load in periodic mode stops counting
        cur_req = "R4";
        wr(3'd6, 32'd0);
        wr(3'd1, 32'd0);
        wait_cyc(5);
        chk("R4", 3'd3, 32'd0);
        chk("R4", 3'd4, 32'd0);

        // R7 free-running 16-bit wrap
        cur_req = "R7";
        wr(3'd0, 32'h00);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h80);
        wait_cyc(1);
        chk("R7", 3'd3, 32'd1);
        wait_cyc(1);
        chk("R9", 3'd4, 32'd1);
        wait_cyc(1);
        chk("R7", 3'd3, 32'h0000_FFFF);

        // R8 upper half kept across width changes
        cur_req = "R8";
        wr(3'd0, 32'h00);
        wr(3'd1, 32'h1234_0002);
        chk("R8", 3'd3, 32'h1234_0002);
        wr(3'd0, 32'h80);
        wait_cyc(2);
        chk("R8", 3'd3, 32'h1234_0000);
        wait_cyc(1);
        chk("R8", 3'd3, 32'h1234_FFFF);
        wr(3'd0, 32'h02);
        chk("R8", 3'd3, 32'h1234_FFFD);
        wr(3'd0, 32'h82);
        wait_cyc(1);
        chk("R8", 3'd3, 32'h1234_FFFC);
        wr(3'd0, 32'h00);
        chk("R8", 3'd3, 32'h1234_FFFA);

        // R7 free-running 32-bit wrap
        cur_req = "R7";
        wr(3'd0, 32'h02);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'h82);
        wait_cyc(1);
        chk("R7", 3'd3, 32'd0);
        wait_cyc(1);
        chk("R7", 3'd3, 32'hFFFF_FFFF);

        // R3 prescale 16 and code 11
        cur_req = "R3";
        wr(3'd0, 32'h02);
        wr(3'd1, 32'h100);
        wr(3'd0, 32'h86);
        wait_cyc(15);
        chk("R3", 3'd3, 32'h100);
        wait_cyc(1);
        chk("R3", 3'd3, 32'hFF);
        wr(3'd0, 32'h8E);
        chk("R3", 3'd0, 32'h8E);
        reg_offs = 3'd3; #1 v = reg_rdata;
        wait_cyc(255);
        chk("R3", 3'd3, v);
        wait_cyc(1);
        chk("R3", 3'd3, v - 1);

        // R10 one-shot halt and restart, R9 set wins over clear
        cur_req = "R10";
        wr(3'd0, 32'h41);
        wr(3'd1, 32'd2);
        wr(3'd6, 32'd0);
        wr(3'd0, 32'hC1);
        wait_cyc(1);
        chk("R10", 3'd3, 32'd1);
        wait_cyc(1);
        chk("R10", 3'd3, 32'd0);
        wait_cyc(5);
        chk("R10", 3'd3, 32'd0);
        wr(3'd0, 32'hC1);
        wait_cyc(1);
        chk("R10", 3'd3, 32'd2);
        cur_req = "R9";
        wr(3'd6, 32'd0);
        chk("R9", 3'd4, 32'd1);
        wait_cyc(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule